// File: doc/BRIEF.md
# Predicated Truncating Vector Byte Store

This block drains one wide vector register to memory one byte at a time. A start command carries the vector contents, a byte-granular predicate mask and a 2-bit element-size code. It also carries a 64-bit base address, a 64-bit index, a flag marking the base as the stack pointer, and the register number the index came from. The sequencer walks the elements from lowest to highest. For each active element it emits one byte write, holding the low byte of that element, on a valid/ready memory port.

The address of element 0 is base plus index. The address then rises by one byte per element, whether or not that element was written. The index is only read and is never returned. A command naming index register 31 is an illegal encoding and is refused. A stack-pointer base that is not 16-byte aligned raises a fault and no byte is stored. Each element takes exactly one cycle plus any cycles spent waiting on the memory port, so the run time depends on the predicate and on the port, never on the stored values.

Top module: `trunc_byte_store`

## Requirements
- R1: The element width in bytes is 1 << cmd_size (size code 0..3 gives 1, 2, 4 or 8 bytes), and the element count is (VL/8) >> cmd_size. For element e, wr_data carries vector bits [8*e*w+7 : 8*e*w], where w is the element width in bytes: only the element's lowest byte is stored.
- R2: Element e is active when predicate bit e*w is set. An inactive element produces no write on the memory port.
- R3: The first element's address is cmd_base + cmd_index (modulo 2^64). Elements are handled in ascending order, and every element, active or not, advances the address by exactly 1. Consecutive active elements e and e+1 are therefore written at adjacent addresses.
- R4: At most one write is offered per cycle. While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold steady.
- R5: After an accepted command, done is high for exactly one cycle, N+1+S cycles after the start edge. N is the element count and S is the number of cycles in which a write waited on wr_ready.
- R6: A command with cmd_index_reg equal to 31 is refused. cmd_reject pulses for one cycle, one cycle after the start edge, and no write, no done and no busy follow.
- R7: With cmd_base_is_sp high, at least one active element, and cmd_base[3:0] not zero, align_fault pulses for one cycle, one cycle after the start edge. No write and no done follow.
- R8: With cmd_base_is_sp high and no active element, the alignment check is made only when parameter CHECK_SP_WHEN_IDLE is 1. With the default of 0, a misaligned base completes normally with no writes.
- R9: The cycle count from start to done is the same for any two commands that differ only in vector data.
- R10: A start pulse that arrives while busy is high is ignored, and the running command's writes are unchanged.
- R11: busy is low after reset and between commands. It is high from the cycle after an accepted start up to and including the done cycle.
- R12: After reset, wr_valid, done, align_fault and cmd_reject are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle start of a command, taken only when idle |
| cmd_vec | input | VL | Vector register contents |
| cmd_pred | input | VL/8 | Predicate mask, one bit per vector byte |
| cmd_size | input | 2 | Element size code (width 8 << code bits) |
| cmd_base | input | 64 | Base address |
| cmd_index | input | 64 | Byte index added to the base |
| cmd_base_is_sp | input | 1 | Base comes from the stack pointer |
| cmd_index_reg | input | 5 | Register number of the index (31 is illegal) |
| busy | output | 1 | Command in progress |
| wr_valid | output | 1 | Byte write offered |
| wr_ready | input | 1 | Memory accepts the offered write |
| wr_addr | output | 64 | Byte write address |
| wr_data | output | 8 | Byte write data |
| done | output | 1 | One-cycle completion pulse |
| align_fault | output | 1 | One-cycle stack-pointer alignment fault pulse |
| cmd_reject | output | 1 | One-cycle illegal-encoding pulse |

## Verification
The bound checker watches the memory port on every cycle. It checks that a stalled write stays unchanged, that back-to-back writes land on adjacent addresses, that writes appear only while busy, that done lasts one cycle and is followed by idle, and that the three outcome pulses never coincide. The values themselves can only be shown by the bench scenarios: which elements are active, which byte of each element is stored, the starting address, the exact cycle count, and the handling of refused, faulting and idle stack-pointer commands. Random vectors, masks, sizes and ready patterns are compared against an independent expected write list and cycle count.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    localparam int unsigned ADDR_W        = 64;
    localparam int unsigned SP_ALIGN_BITS = 4;
    localparam logic [4:0]  BAD_INDEX_REG = 5'd31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } tbs_state_e;

    typedef enum logic [1:0] {
        VERDICT_GO,
        VERDICT_REJECT,
        VERDICT_FAULT
    } tbs_verdict_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } tbs_wr_t;

    // Bytes per element for a size code.
    function automatic int unsigned elem_bytes(input logic [1:0] sz);
        return 32'd1 << sz;
    endfunction

endpackage

// File: rtl/tbs_cmd_check.sv
module tbs_cmd_check
    import tbs_pkg::*;
#(
    parameter int unsigned VL                 = 256,
    parameter bit          CHECK_SP_WHEN_IDLE = 1'b0
) (
    input  logic [VL/8-1:0]   pred,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] base,
    input  logic              base_is_sp,
    input  logic [4:0]        index_reg,
    output tbs_verdict_e      verdict
);
    localparam int unsigned PB   = VL / 8;
    localparam int unsigned BI_W = $clog2(PB);

    logic [BI_W-1:0] grp_mask;
    logic            any_act;
    logic            misaligned;

    assign grp_mask = BI_W'(elem_bytes(size) - 32'd1);

    // An element is represented by the predicate bit at its lowest byte.
    always_comb begin
        any_act = 1'b0;
        for (int b = 0; b < PB; b++) begin
            if (pred[b] && ((BI_W'(b) & grp_mask) == '0)) begin
                any_act = 1'b1;
            end
        end
    end

    assign misaligned = (base[SP_ALIGN_BITS-1:0] != '0);

    always_comb begin
        if (index_reg == BAD_INDEX_REG) begin
            verdict = VERDICT_REJECT;
        end else if (base_is_sp && (any_act || CHECK_SP_WHEN_IDLE) && misaligned) begin
            verdict = VERDICT_FAULT;
        end else begin
            verdict = VERDICT_GO;
        end
    end

endmodule

// File: rtl/tbs_elem_pick.sv
module tbs_elem_pick
    import tbs_pkg::*;
#(
    parameter int unsigned VL = 256
) (
    input  logic [VL-1:0]                vec,
    input  logic [VL/8-1:0]              pred,
    input  logic [1:0]                   size,
    input  logic [$clog2(VL/8)-1:0]      elem,
    output logic                         active,
    output logic [7:0]                   lo_byte
);
    localparam int unsigned PB   = VL / 8;
    localparam int unsigned BI_W = $clog2(PB);

    logic [BI_W-1:0] byte_idx;

    // Byte offset of the element inside the vector.
    assign byte_idx = elem << size;
    assign active   = pred[byte_idx];
    assign lo_byte  = vec[{byte_idx, 3'b000} +: 8];

endmodule

// File: rtl/tbs_seq.sv
module tbs_seq
    import tbs_pkg::*;
#(
    parameter int unsigned VL = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  tbs_verdict_e             verdict,
    input  logic [VL-1:0]            cmd_vec,
    input  logic [VL/8-1:0]          cmd_pred,
    input  logic [1:0]               cmd_size,
    input  logic [ADDR_W-1:0]        cmd_base,
    input  logic [ADDR_W-1:0]        cmd_index,
    input  logic                     elem_active,
    input  logic                     wr_ready,
    output tbs_state_e               state,
    output logic [$clog2(VL/8)-1:0]  elem,
    output logic [VL-1:0]            vec_q,
    output logic [VL/8-1:0]          pred_q,
    output logic [1:0]               size_q,
    output logic [ADDR_W-1:0]        addr_q,
    output logic                     fault_q,
    output logic                     reject_q
);
    localparam int unsigned PB   = VL / 8;
    localparam int unsigned BI_W = $clog2(PB);

    logic [BI_W-1:0] last_idx;
    logic            step;

    assign last_idx = BI_W'((PB >> size_q) - 1);
    // An inactive element never waits; an active one waits for the port.
    assign step     = !elem_active || wr_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            elem     <= '0;
            vec_q    <= '0;
            pred_q   <= '0;
            size_q   <= '0;
            addr_q   <= '0;
            fault_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            fault_q  <= 1'b0;
            reject_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        unique case (verdict)
                            VERDICT_REJECT: reject_q <= 1'b1;
                            VERDICT_FAULT:  fault_q  <= 1'b1;
                            default: begin
                                vec_q  <= cmd_vec;
                                pred_q <= cmd_pred;
                                size_q <= cmd_size;
                                addr_q <= cmd_base + cmd_index;
                                elem   <= '0;
                                state  <= ST_RUN;
                            end
                        endcase
                    end
                end
                ST_RUN: begin
                    if (step) begin
                        addr_q <= addr_q + ADDR_W'(1);
                        if (elem == last_idx) begin
                            state <= ST_FIN;
                        end else begin
                            elem <= elem + BI_W'(1);
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/trunc_byte_store.sv
module trunc_byte_store
    import tbs_pkg::*;
#(
    parameter int unsigned VL                 = 256,
    parameter bit          CHECK_SP_WHEN_IDLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [VL-1:0]     cmd_vec,
    input  logic [VL/8-1:0]   cmd_pred,
    input  logic [1:0]        cmd_size,
    input  logic [63:0]       cmd_base,
    input  logic [63:0]       cmd_index,
    input  logic              cmd_base_is_sp,
    input  logic [4:0]        cmd_index_reg,
    output logic              busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [63:0]       wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              align_fault,
    output logic              cmd_reject
);
    localparam int unsigned PB   = VL / 8;
    localparam int unsigned BI_W = $clog2(PB);

    tbs_verdict_e     verdict;
    tbs_state_e       state;
    logic [BI_W-1:0]  elem;
    logic [VL-1:0]    vec_q;
    logic [PB-1:0]    pred_q;
    logic [1:0]       size_q;
    logic [63:0]      addr_q;
    logic             elem_active;
    logic [7:0]       lo_byte;
    tbs_wr_t          wr;

    tbs_cmd_check #(
        .VL                 (VL),
        .CHECK_SP_WHEN_IDLE (CHECK_SP_WHEN_IDLE)
    ) check_i (
        .pred       (cmd_pred),
        .size       (cmd_size),
        .base       (cmd_base),
        .base_is_sp (cmd_base_is_sp),
        .index_reg  (cmd_index_reg),
        .verdict    (verdict)
    );

    tbs_seq #(
        .VL (VL)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start       (cmd_start),
        .verdict     (verdict),
        .cmd_vec     (cmd_vec),
        .cmd_pred    (cmd_pred),
        .cmd_size    (cmd_size),
        .cmd_base    (cmd_base),
        .cmd_index   (cmd_index),
        .elem_active (elem_active),
        .wr_ready    (wr_ready),
        .state       (state),
        .elem        (elem),
        .vec_q       (vec_q),
        .pred_q      (pred_q),
        .size_q      (size_q),
        .addr_q      (addr_q),
        .fault_q     (align_fault),
        .reject_q    (cmd_reject)
    );

    tbs_elem_pick #(
        .VL (VL)
    ) pick_i (
        .vec     (vec_q),
        .pred    (pred_q),
        .size    (size_q),
        .elem    (elem),
        .active  (elem_active),
        .lo_byte (lo_byte)
    );

    assign wr.addr  = addr_q;
    assign wr.data  = lo_byte;
    assign wr_addr  = wr.addr;
    assign wr_data  = wr.data;
    assign wr_valid = (state == ST_RUN) && elem_active;
    assign done     = (state == ST_FIN);
    assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/tbs_checker.sv
module tbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [63:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        done,
    input logic        align_fault,
    input logic        cmd_reject
);

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R11
    wr_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (busy && !done));

    // R3
    addr_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + 64'd1)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R6
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, align_fault, cmd_reject}));

    // R6
    reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> (!busy && !wr_valid));

    // R7
    fault_idle_chk: assert property (@(posedge clk) disable iff (rst)
        align_fault |=> (!busy && !align_fault));

endmodule

bind trunc_byte_store tbs_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .done        (done),
    .align_fault (align_fault),
    .cmd_reject  (cmd_reject)
);

// File: tb/trunc_byte_store_tb_top.sv
module trunc_byte_store_tb_top;

    localparam int unsigned VL     = 256;
    localparam int unsigned PB     = VL / 8;
    localparam time         PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst;
    logic            cmd_start;
    logic [VL-1:0]   cmd_vec;
    logic [PB-1:0]   cmd_pred;
    logic [1:0]      cmd_size;
    logic [63:0]     cmd_base;
    logic [63:0]     cmd_index;
    logic            cmd_base_is_sp;
    logic [4:0]      cmd_index_reg;
    logic            busy;
    logic            wr_valid;
    logic            wr_ready;
    logic [63:0]     wr_addr;
    logic [7:0]      wr_data;
    logic            done;
    logic            align_fault;
    logic            cmd_reject;

    int checks = 0;
    int errors = 0;
    int last_cycles = 0;

    logic [63:0] exp_addr [PB];
    logic [7:0]  exp_data [PB];
    int          exp_n;

    always #(PERIOD/2) clk = ~clk;

    trunc_byte_store #(.VL(VL)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .cmd_start      (cmd_start),
        .cmd_vec        (cmd_vec),
        .cmd_pred       (cmd_pred),
        .cmd_size       (cmd_size),
        .cmd_base       (cmd_base),
        .cmd_index      (cmd_index),
        .cmd_base_is_sp (cmd_base_is_sp),
        .cmd_index_reg  (cmd_index_reg),
        .busy           (busy),
        .wr_valid       (wr_valid),
        .wr_ready       (wr_ready),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .done           (done),
        .align_fault    (align_fault),
        .cmd_reject     (cmd_reject)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Expected write list from the requirements (R1, R2, R3).
    function automatic int build_expect(input logic [VL-1:0] v, input logic [PB-1:0] p,
                                        input logic [1:0] sz, input logic [63:0] b,
                                        input logic [63:0] ix);
        int n = 0;
        int w = 1 << sz;
        for (int e = 0; e < (PB >> sz); e++) begin
            if (p[e*w]) begin
                exp_addr[n] = b + ix + 64'(e);
                exp_data[n] = v[e*w*8 +: 8];
                n++;
            end
        end
        return n;
    endfunction

    function automatic bit any_active(input logic [PB-1:0] p, input logic [1:0] sz);
        for (int e = 0; e < (PB >> sz); e++) if (p[e << sz]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic run_cmd(input logic [VL-1:0] v, input logic [PB-1:0] p,
                           input logic [1:0] sz, input logic [63:0] b,
                           input logic [63:0] ix, input logic sp,
                           input logic [4:0] ireg, input int ready_pct,
                           input bit poke_busy);
        int n       = PB >> sz;
        bit rej     = (ireg == 5'd31);
        bit flt     = !rej && sp && any_active(p, sz) && (b[3:0] != 4'd0);
        int cyc     = 1;
        int k       = 0;
        int stalls  = 0;
        bit seen    = 0;
        exp_n = build_expect(v, p, sz, b, ix);
        @(negedge clk);
        cmd_vec = v; cmd_pred = p; cmd_size = sz; cmd_base = b; cmd_index = ix;
        cmd_base_is_sp = sp; cmd_index_reg = ireg; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        if (rej || flt) begin
            #1;
            if (rej) chk(cmd_reject === 1'b1, "R6 reject pulse", 64'(cmd_reject), 64'd1);
            else     chk(align_fault === 1'b1, "R7 fault pulse", 64'(align_fault), 64'd1);
            chk(busy === 1'b0 && wr_valid === 1'b0, "R6/R7 no run", 64'({busy, wr_valid}), 64'd0);
            @(negedge clk); #1;
            chk(!busy && !done && !wr_valid && !cmd_reject && !align_fault,
                "R6/R7 stays idle", 64'({busy, done, wr_valid, cmd_reject, align_fault}), 64'd0);
            return;
        end
        chk(busy === 1'b1, "R11 busy after start", 64'(busy), 64'd1);
        while (cyc < 200) begin
            if (poke_busy && cyc == 3) begin
                cmd_start = 1'b1; cmd_base = ~b; cmd_pred = ~p; cmd_vec = ~v;
            end else begin
                cmd_start = 1'b0;
            end
            wr_ready = (int'($urandom % 100) < ready_pct);
            #1;
            if (done) begin
                seen = 1;
                break;
            end
            if (wr_valid) begin
                if (k < exp_n) begin
                    chk(wr_addr === exp_addr[k], "R3 write address", wr_addr, exp_addr[k]);
                    chk(wr_data === exp_data[k], "R1/R2 write data", 64'(wr_data), 64'(exp_data[k]));
                end else begin
                    chk(1'b0, "R2 extra write", 64'(k), 64'(exp_n));
                end
                if (wr_ready) k++;
                else stalls++;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_start = 1'b0;
        chk(seen, "R5 done seen", 64'(seen), 64'd1);
        chk(k == exp_n, "R2 write count", 64'(k), 64'(exp_n));
        chk(cyc == n + 1 + stalls, "R5 cycle count", 64'(cyc), 64'(n + 1 + stalls));
        last_cycles = cyc;
        @(negedge clk); #1;
        chk(!done && !busy, "R11 idle after done", 64'({done, busy}), 64'd0);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [VL-1:0] va;
        int c1;
        void'($urandom(32'd20240611));
        rst = 1'b1; cmd_start = 1'b0; cmd_vec = '0; cmd_pred = '0; cmd_size = 2'd0;
        cmd_base = '0; cmd_index = '0; cmd_base_is_sp = 1'b0; cmd_index_reg = 5'd2;
        wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R12
        chk(!wr_valid && !done && !align_fault && !cmd_reject && !busy, "R12 reset state",
            64'({wr_valid, done, align_fault, cmd_reject, busy}), 64'd0);

        // R1 each size, all bytes active, always ready
        for (int s = 0; s < 4; s++) begin
            run_cmd(rand_vec(), '1, 2'(s), 64'h1000, 64'd5, 1'b0, 5'd3, 100, 1'b0);
        end
        // R2 odd predicate bits only: with size >= 1 nothing is active
        run_cmd(rand_vec(), {PB/2{2'b10}}, 2'd1, 64'h2000, 64'd0, 1'b0, 5'd4, 100, 1'b0);
        // R3 wrap of base + index
        run_cmd(rand_vec(), '1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 1'b0, 5'd1, 60, 1'b0);
        // R4 heavy stalls
        run_cmd(rand_vec(), {PB/4{4'b0101}}, 2'd0, 64'h40, 64'h3, 1'b0, 5'd7, 20, 1'b0);
        // R6 illegal index register
        run_cmd(rand_vec(), '1, 2'd0, 64'h0, 64'h0, 1'b0, 5'd31, 100, 1'b0);
        // R7 stack pointer misaligned with active elements
        run_cmd(rand_vec(), '1, 2'd3, 64'h1008, 64'h0, 1'b1, 5'd0, 100, 1'b0);
        // R7 stack pointer aligned runs
        run_cmd(rand_vec(), '1, 2'd3, 64'h1010, 64'h9, 1'b1, 5'd0, 100, 1'b0);
        // R8 stack pointer misaligned, nothing active: completes with no writes
        run_cmd(rand_vec(), '0, 2'd2, 64'h1003, 64'h0, 1'b1, 5'd0, 100, 1'b0);
        // R10 start pulse while busy is ignored
        run_cmd(rand_vec(), '1, 2'd0, 64'h500, 64'h10, 1'b0, 5'd8, 100, 1'b1);
        // R9 data-independent timing
        va = rand_vec();
        run_cmd(va, 32'h0F0F_3355, 2'd0, 64'h800, 64'h0, 1'b0, 5'd9, 100, 1'b0);
        c1 = last_cycles;
        run_cmd(~va, 32'h0F0F_3355, 2'd0, 64'h800, 64'h0, 1'b0, 5'd9, 100, 1'b0);
        chk(c1 == last_cycles, "R9 same timing for other data", 64'(last_cycles), 64'(c1));

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [PB-1:0] p = PB'($urandom);
            logic [63:0]   b = {$urandom, $urandom};
            logic          sp = ($urandom % 3) == 0;
            logic [4:0]    ir = (($urandom % 10) == 0) ? 5'd31 : 5'($urandom % 31);
            if (($urandom % 4) == 0) p = '0;
            if (sp && ($urandom % 2) == 0) b[3:0] = 4'd0;
            run_cmd(rand_vec(), p, 2'($urandom), b, {$urandom, $urandom}, sp, ir,
                    30 + int'($urandom % 71), ($urandom % 5) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule